// File: doc/BRIEF.md
# Probe Capture Engine with Serial Readout

This block is an embedded signal recorder. A wide bus of internal probe signals is sampled on the clock of the design under observation. A host on the far end of a serial line sets a trigger pattern, arms the engine and later pulls out the recorded samples. Unused probe bits are tied to zero so that the bus always has its full width.

Once armed, the engine compares every sample with the trigger pattern under a bit mask. The first matching sample becomes sample 0, and the engine records consecutive samples until the buffer is full. It then holds the buffer until the host asks for it. The readout streams each sample as a series of bytes over an 8N1 serial transmitter. The link is paced by the transmitter, so no byte is dropped.

Top module: `probe_capture_top`

## Requirements
- R1: After reset the engine is idle, the serial output rests at logic 1, and the mask and pattern registers hold zero.
- R2: Opcode 0x4D followed by WIDTH/8 payload bytes loads the mask. Opcode 0x56 followed by WIDTH/8 payload bytes loads the pattern. Payload bytes arrive least significant byte first.
- R3: Opcode 0x41 received while idle arms the engine. While armed, nothing is recorded until (probe & mask) == (pattern & mask).
- R4: The matching sample is stored as sample 0. The following DEPTH-1 clock cycles are stored as samples 1 to DEPTH-1, and no sample from before the match is kept.
- R5: After DEPTH samples the engine holds its buffer and ignores further probe activity.
- R6: Opcode 0x52 received while holding streams DEPTH*WIDTH/8 bytes: sample 0 first, each sample least significant byte first. The engine then returns to idle.
- R7: Every transmitted byte is framed as one low start bit, eight data bits LSB first and one high stop bit, each BAUD_DIV clock cycles long. The line idles high.
- R8: While the transmitter is busy, the readout waits and holds its pending byte. Every byte of the buffer is therefore delivered exactly once.
- R9: An arm opcode received while holding discards the buffer and starts a new armed phase.
- R10: Mask and pattern loads are ignored unless the engine is idle or holding. A read opcode is ignored unless the engine is holding.
- R11: A received frame whose stop bit is low is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock from the observed design |
| rst_n | input | 1 | Asynchronous active-low reset |
| probe | input | WIDTH | Probe bus, unused bits tied low |
| host_rx | input | 1 | Serial command input from host |
| host_tx | output | 1 | Serial data output to host |

## Verification
Two functions can land in the same cycle: an arm command taking effect and the trigger match. A probe that already matches when the arm opcode arrives makes the first armed cycle record sample 0. The bench provokes this by holding the trigger field of the probe at the pattern while a free-running count fills the low bits. The result is judged from the bytes that come back: every sample must carry the pattern, and the counts must rise by exactly one from sample to sample, with no gap and no duplicate.

// File: rtl/probe_capture_pkg.sv
package probe_capture_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ARMED   = 3'd1,
    ST_CAPTURE = 3'd2,
    ST_HOLD    = 3'd3,
    ST_READOUT = 3'd4
  } cap_state_t;

  localparam logic [7:0] OP_MASK  = 8'h4D;
  localparam logic [7:0] OP_PATT  = 8'h56;
  localparam logic [7:0] OP_ARM   = 8'h41;
  localparam logic [7:0] OP_READ  = 8'h52;

endpackage

// File: rtl/serial_rx.sv
module serial_rx #(
  parameter int BAUD_DIV = 868
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_i,
  output logic       byte_vld,
  output logic [7:0] byte_o
);
  localparam int CW   = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;
  localparam int HALF = BAUD_DIV / 2;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;

  rx_state_t      st_q, st_d;
  logic [1:0]     sync_q;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [2:0]     bit_q, bit_d;
  logic [7:0]     sh_q, sh_d;
  logic           vld_d, vld_q;
  logic           line_s;

  assign line_s = sync_q[1];

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    vld_d = 1'b0;
    unique case (st_q)
      RX_IDLE: begin
        cnt_d = '0;
        if (!line_s) st_d = RX_START;
      end
      RX_START: begin
        if (cnt_q == CW'(HALF - 1)) begin
          cnt_d = '0;
          bit_d = '0;
          st_d  = line_s ? RX_IDLE : RX_DATA;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      RX_DATA: begin
        if (cnt_q == CW'(BAUD_DIV - 1)) begin
          cnt_d = '0;
          sh_d  = {line_s, sh_q[7:1]};
          bit_d = bit_q + 1'b1;
          if (bit_q == 3'd7) st_d = RX_STOP;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      RX_STOP: begin
        if (cnt_q == CW'(BAUD_DIV - 1)) begin
          cnt_d = '0;
          vld_d = line_s;
          st_d  = RX_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      vld_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], line_i};
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      vld_q  <= vld_d;
    end
  end

  assign byte_vld = vld_q;
  assign byte_o   = sh_q;
endmodule

// File: rtl/serial_tx.sv
module serial_tx #(
  parameter int BAUD_DIV = 868
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       send,
  input  logic [7:0] data_i,
  output logic       ready,
  output logic       busy,
  output logic       line_o
);
  localparam int CW = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;

  logic [9:0]    sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [3:0]    bit_q, bit_d;
  logic          busy_q, busy_d;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    busy_d = busy_q;
    if (!busy_q) begin
      if (send) begin
        sh_d   = {1'b1, data_i, 1'b0};
        cnt_d  = '0;
        bit_d  = '0;
        busy_d = 1'b1;
      end
    end else if (cnt_q == CW'(BAUD_DIV - 1)) begin
      cnt_d = '0;
      sh_d  = {1'b1, sh_q[9:1]};
      bit_d = bit_q + 1'b1;
      if (bit_q == 4'd9) busy_d = 1'b0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      bit_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      busy_q <= busy_d;
    end
  end

  assign ready  = !busy_q;
  assign busy   = busy_q;
  assign line_o = sh_q[0];
endmodule

// File: rtl/cmd_decoder.sv
module cmd_decoder
  import probe_capture_pkg::*;
#(
  parameter int WIDTH = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic [7:0]       byte_i,
  input  logic             cfg_open,
  output logic             arm_cmd,
  output logic             read_cmd,
  output logic [WIDTH-1:0] mask_o,
  output logic [WIDTH-1:0] patt_o
);
  localparam int NB = WIDTH / 8;
  localparam int BW = (NB > 1) ? $clog2(NB) : 1;

  logic             payload_q, payload_d;
  logic             sel_patt_q, sel_patt_d;
  logic [BW-1:0]    bcnt_q, bcnt_d;
  logic [WIDTH-1:0] stage_q, stage_d;
  logic [WIDTH-1:0] mask_q, mask_d, patt_q, patt_d;
  logic [WIDTH-1:0] shifted;

  assign shifted = {byte_i, stage_q[WIDTH-1:8]};

  always_comb begin
    payload_d  = payload_q;
    sel_patt_d = sel_patt_q;
    bcnt_d     = bcnt_q;
    stage_d    = stage_q;
    mask_d     = mask_q;
    patt_d     = patt_q;
    arm_cmd    = 1'b0;
    read_cmd   = 1'b0;
    if (byte_vld) begin
      if (!payload_q) begin
        bcnt_d = '0;
        unique case (byte_i)
          OP_MASK: begin payload_d = 1'b1; sel_patt_d = 1'b0; end
          OP_PATT: begin payload_d = 1'b1; sel_patt_d = 1'b1; end
          OP_ARM:  arm_cmd  = 1'b1;
          OP_READ: read_cmd = 1'b1;
          default: ;
        endcase
      end else begin
        stage_d = shifted;
        bcnt_d  = bcnt_q + 1'b1;
        if (bcnt_q == BW'(NB - 1)) begin
          payload_d = 1'b0;
          if (cfg_open) begin
            if (sel_patt_q) patt_d = shifted;
            else            mask_d = shifted;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      payload_q  <= 1'b0;
      sel_patt_q <= 1'b0;
      bcnt_q     <= '0;
      stage_q    <= '0;
      mask_q     <= '0;
      patt_q     <= '0;
    end else begin
      payload_q  <= payload_d;
      sel_patt_q <= sel_patt_d;
      bcnt_q     <= bcnt_d;
      stage_q    <= stage_d;
      mask_q     <= mask_d;
      patt_q     <= patt_d;
    end
  end

  assign mask_o = mask_q;
  assign patt_o = patt_q;
endmodule

// File: rtl/capture_ctrl.sv
module capture_ctrl
  import probe_capture_pkg::*;
#(
  parameter int WIDTH = 128,
  parameter int DEPTH = 512
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [WIDTH-1:0]        probe,
  input  logic [WIDTH-1:0]        mask,
  input  logic [WIDTH-1:0]        patt,
  input  logic                    arm_cmd,
  input  logic                    read_cmd,
  input  logic                    tx_ready,
  output logic                    tx_valid,
  output logic [7:0]              tx_byte,
  output logic                    cfg_open,
  output cap_state_t              state,
  output logic                    wr_en,
  output logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] wr_addr
);
  localparam int NB = WIDTH / 8;
  localparam int BW = (NB > 1) ? $clog2(NB) : 1;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  cap_state_t       st_q, st_d;
  logic [AW-1:0]    wa_q, wa_d, ra_q, ra_d;
  logic [BW-1:0]    bi_q, bi_d;
  logic             hit;
  logic [WIDTH-1:0] buf_mem [DEPTH];
  logic [WIDTH-1:0] rd_word;

  assign hit      = ((probe & mask) == (patt & mask));
  assign wr_en    = ((st_q == ST_ARMED) && hit) || (st_q == ST_CAPTURE);
  assign cfg_open = (st_q == ST_IDLE) || (st_q == ST_HOLD);
  assign tx_valid = (st_q == ST_READOUT);
  assign rd_word  = buf_mem[ra_q];
  assign tx_byte  = rd_word[{bi_q, 3'b000} +: 8];

  always_comb begin
    st_d = st_q;
    wa_d = wa_q;
    ra_d = ra_q;
    bi_d = bi_q;
    unique case (st_q)
      ST_IDLE: begin
        if (arm_cmd) begin
          st_d = ST_ARMED;
          wa_d = '0;
        end
      end
      ST_ARMED, ST_CAPTURE: begin
        if (wr_en) begin
          if (wa_q == AW'(DEPTH - 1)) begin
            st_d = ST_HOLD;
          end else begin
            st_d = ST_CAPTURE;
            wa_d = wa_q + 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (arm_cmd) begin
          st_d = ST_ARMED;
          wa_d = '0;
        end else if (read_cmd) begin
          st_d = ST_READOUT;
          ra_d = '0;
          bi_d = '0;
        end
      end
      ST_READOUT: begin
        if (tx_ready) begin
          if (bi_q == BW'(NB - 1)) begin
            bi_d = '0;
            if (ra_q == AW'(DEPTH - 1)) st_d = ST_IDLE;
            else                        ra_d = ra_q + 1'b1;
          end else begin
            bi_d = bi_q + 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      wa_q <= '0;
      ra_q <= '0;
      bi_q <= '0;
    end else begin
      st_q <= st_d;
      wa_q <= wa_d;
      ra_q <= ra_d;
      bi_q <= bi_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) buf_mem[wa_q] <= probe;
  end

  assign state   = st_q;
  assign wr_addr = wa_q;
endmodule

// File: rtl/probe_capture_top.sv
module probe_capture_top
  import probe_capture_pkg::*;
#(
  parameter int WIDTH    = 128,
  parameter int DEPTH    = 512,
  parameter int BAUD_DIV = 868
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] probe,
  input  logic             host_rx,
  output logic             host_tx
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [1:0]       rst_sync_q;
  logic             rst_i_n;
  logic             rx_vld;
  logic [7:0]       rx_byte;
  logic             arm_cmd, read_cmd, cfg_open;
  logic [WIDTH-1:0] mask, patt;
  logic             tx_valid, tx_ready, tx_busy;
  logic [7:0]       tx_byte;
  cap_state_t       state;
  logic             wr_en;
  logic [AW-1:0]    wr_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  serial_rx #(.BAUD_DIV(BAUD_DIV)) u_rx (
    .clk(clk), .rst_n(rst_i_n), .line_i(host_rx),
    .byte_vld(rx_vld), .byte_o(rx_byte)
  );

  cmd_decoder #(.WIDTH(WIDTH)) u_dec (
    .clk(clk), .rst_n(rst_i_n), .byte_vld(rx_vld), .byte_i(rx_byte),
    .cfg_open(cfg_open), .arm_cmd(arm_cmd), .read_cmd(read_cmd),
    .mask_o(mask), .patt_o(patt)
  );

  capture_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_i_n), .probe(probe), .mask(mask), .patt(patt),
    .arm_cmd(arm_cmd), .read_cmd(read_cmd), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .cfg_open(cfg_open),
    .state(state), .wr_en(wr_en), .wr_addr(wr_addr)
  );

  serial_tx #(.BAUD_DIV(BAUD_DIV)) u_tx (
    .clk(clk), .rst_n(rst_i_n), .send(tx_valid), .data_i(tx_byte),
    .ready(tx_ready), .busy(tx_busy), .line_o(host_tx)
  );
endmodule

// File: rtl/probe_capture_checker.sv
module probe_capture_checker
  import probe_capture_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    host_tx,
  input cap_state_t              state,
  input logic                    wr_en,
  input logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] wr_addr,
  input logic                    tx_valid,
  input logic                    tx_ready,
  input logic [7:0]              tx_byte,
  input logic                    tx_busy
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  assert_idle_line_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> host_tx);

  assert_hold_pending_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && state == ST_READOUT) |=> (tx_valid && $stable(tx_byte)));

  assert_consecutive_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != AW'(DEPTH - 1)) |=> (wr_en && wr_addr == $past(wr_addr) + 1'b1));

  assert_armed_match_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARMED && wr_en && wr_addr != AW'(DEPTH - 1)) |=> state == ST_CAPTURE);

  assert_readout_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_READOUT |=> (state == ST_READOUT || state == ST_IDLE));

  always_comb begin
    if (rst_n && (state == ST_HOLD || state == ST_IDLE || state == ST_READOUT))
      assert_no_write_when_full_R5: assert (!wr_en);
  end
endmodule

bind probe_capture_top probe_capture_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_i_n), .host_tx(host_tx), .state(state),
  .wr_en(wr_en), .wr_addr(wr_addr), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_byte(tx_byte), .tx_busy(tx_busy)
);

// File: tb/tb_probe_capture_top.sv
`timescale 1ns/1ps
module tb_probe_capture_top;
  localparam int WIDTH = 32;
  localparam int DEPTH = 8;
  localparam int DIV   = 8;
  localparam int NB    = WIDTH / 8;

  logic             clk, rst_n, host_rx, host_tx;
  logic [WIDTH-1:0] probe;
  logic [7:0]       top_f;
  logic [23:0]      cnt;
  int               checks, errors, rx_count;
  logic [7:0]       exp_q[$];
  logic [7:0]       free_q[$];

  probe_capture_top #(.WIDTH(WIDTH), .DEPTH(DEPTH), .BAUD_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .probe(probe), .host_rx(host_rx), .host_tx(host_tx)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  assign probe = {top_f, cnt};
  always @(negedge clk) cnt <= cnt + 24'd1;

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: decodes the serial output, pops the scoreboard
  initial begin
    logic [7:0] b;
    forever begin
      @(negedge clk);
      if (rst_n && host_tx == 1'b0) begin
        repeat (DIV/2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (DIV) @(negedge clk);
          b[i] = host_tx;
        end
        repeat (DIV) @(negedge clk);
        check(host_tx == 1'b1, "R7 stop bit", {31'd0, host_tx}, 32'd1);
        rx_count++;
        if (exp_q.size() > 0) begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(b == e, "R6 readout byte", {24'd0, b}, {24'd0, e});
        end else begin
          free_q.push_back(b);
        end
      end
    end
  end

  task automatic send_byte(input logic [7:0] d, input bit good_stop = 1'b1);
    host_rx = 1'b0;
    repeat (DIV) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      host_rx = d[i];
      repeat (DIV) @(negedge clk);
    end
    host_rx = good_stop;
    repeat (DIV) @(negedge clk);
    host_rx = 1'b1;
    repeat (2*DIV) @(negedge clk);
  endtask

  task automatic load(input logic [7:0] op, input logic [WIDTH-1:0] v);
    send_byte(op);
    for (int i = 0; i < NB; i++) send_byte(v[8*i +: 8]);
  endtask

  // Raises the trigger field and returns the count stored as sample 0
  task automatic fire(output logic [23:0] c0);
    @(negedge clk);
    top_f = 8'hA5;
    @(posedge clk);
    c0 = cnt;
    repeat (DEPTH + 4) @(negedge clk);
  endtask

  task automatic expect_samples(input logic [23:0] c0);
    for (int s = 0; s < DEPTH; s++) begin
      logic [WIDTH-1:0] w;
      w = {8'hA5, c0 + 24'(s)};
      for (int k = 0; k < NB; k++) exp_q.push_back(w[8*k +: 8]);
    end
  endtask

  task automatic drain(input string req);
    int n;
    n = 0;
    while (exp_q.size() > 0 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    repeat (4*DIV) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    logic [23:0] c0, c1;
    int base;
    checks = 0; errors = 0; rx_count = 0;
    host_rx = 1'b1; top_f = 8'h00; cnt = '0; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1: line idle high, nothing sent
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(host_tx == 1'b1, "R1 idle line", {31'd0, host_tx}, 32'd1);
    end

    // R10: read while idle is ignored
    send_byte(8'h52);
    repeat (300) @(negedge clk);
    check(rx_count == 0, "R10 read in idle", rx_count, 0);

    // R2 R3 R4 R5 R6 R8: basic capture, LSB-first config
    load(8'h4D, 32'hFF00_0000);
    load(8'h56, 32'hA500_0000);
    send_byte(8'h41);
    repeat (40) @(negedge clk);
    fire(c0);
    repeat (50) @(negedge clk);   // R5: probe keeps moving while held
    expect_samples(c0);
    send_byte(8'h52);
    drain("R6 all bytes delivered R8");
    check(free_q.size() == 0, "R8 no extra bytes", free_q.size(), 0);

    // R10: mask load during armed phase is ignored
    top_f = 8'h00;
    send_byte(8'h41);
    load(8'h4D, 32'h0000_0000);
    repeat (40) @(negedge clk);
    fire(c0);
    expect_samples(c0);
    send_byte(8'h52);
    drain("R10 config ignored when armed");

    // R9: second arm while holding restarts
    top_f = 8'h00;
    send_byte(8'h41);
    repeat (40) @(negedge clk);
    fire(c1);
    top_f = 8'h00;
    send_byte(8'h41);
    repeat (40) @(negedge clk);
    fire(c0);
    check(c0 != c1, "R9 distinct captures", {8'd0, c0}, {8'd0, c1});
    expect_samples(c0);
    send_byte(8'h52);
    drain("R9 restart capture");

    // R11 + coincident arm/trigger: probe already matching at arm time
    send_byte(8'h41);
    repeat (60) @(negedge clk);
    base = rx_count;
    send_byte(8'h52, 1'b0);
    repeat (400) @(negedge clk);
    check(rx_count == base, "R11 bad stop bit discarded", rx_count, base);
    send_byte(8'h52);
    begin
      int n;
      n = 0;
      while (free_q.size() < DEPTH*NB && n < 20000) begin
        @(negedge clk);
        n++;
      end
    end
    check(free_q.size() == DEPTH*NB, "R6 coincident byte count", free_q.size(), DEPTH*NB);
    if (free_q.size() == DEPTH*NB) begin
      logic [WIDTH-1:0] prev, w;
      for (int s = 0; s < DEPTH; s++) begin
        for (int k = 0; k < NB; k++) w[8*k +: 8] = free_q.pop_front();
        check(w[31:24] == 8'hA5, "R3 trigger field", {24'd0, w[31:24]}, 32'hA5);
        if (s > 0)
          check(w[23:0] == prev[23:0] + 24'd1, "R4 consecutive samples",
                {8'd0, w[23:0]}, {8'd0, prev[23:0] + 24'd1});
        prev = w;
      end
    end
    report();
  end
endmodule